// File: doc/BRIEF.md
# Phase-Dimmer Conduction Angle Processor

This block turns the digitised output of a mains-level comparator into a reference code for an LED current loop. The comparator output is high while a phase-cut dimmer conducts. After a glitch filter, two counters run over a measurement interval that spans two rectified half-cycles. One counts the clocks for which the filtered signal is high. The other counts every clock of the interval. A sequential divider turns the ratio into a conduction angle in whole degrees, and a first-order IIR filter smooths it. A lockout counter lets the smoothed angle reach the outputs only once every few half-cycles. When it does, the angle is mapped through one of two piecewise-linear dimming curves into a reference in tenths of a percent of full scale.

Half-cycle boundaries come from an external synchroniser as a one-clock pulse on `half_tick`. The interval between boundaries must be longer than about 16 clocks, so that one result is finished before the next interval ends.

A controller state machine sequences each result through four states:
- **IDLE** waits for a finished interval.
- **DIVIDE** runs the divider.
- **SMOOTH** updates the filter and the lockout count.
- **PUBLISH** registers the new outputs.

The transitions are:
- *measure* (IDLE→DIVIDE): the interval saw at least one filtered edge.
- *bypass* (IDLE→SMOOTH): the interval saw no filtered edge, so the angle is forced to 180.
- *quotient* (DIVIDE→SMOOTH): the divider has finished.
- *hold* (SMOOTH→IDLE): the lockout has not yet expired.
- *release* (SMOOTH→PUBLISH): the lockout has expired.
- *return* (PUBLISH→IDLE): the outputs have been registered.

Top module: `cangle_ref_proc`

## Requirements
- R1: A change of `dim_raw` is accepted by the filtered signal only after `dim_raw` has differed from it on FILT_CYC (default 20) consecutive clocks. A pulse shorter than that has no effect on the measured angle.
- R2: The first `half_tick` after reset arms the timers. After that, each measurement interval runs from one `half_tick` to the second one after it, so it covers two half-cycles. Its angle is A = floor(180·Hc/P), where Hc is the number of clocks in the interval with the filtered signal high and P is the number of clocks in the interval. Unequal high times in the two halves enter only through their sum.
- R3: If the filtered signal has no edge during an interval, that interval's angle A is 180.
- R4: A filtered angle F, held in degrees·16 and reset to 2880, is updated once per interval as F ← F + ((16·A − F) >>> 1), where >>> is an arithmetic shift (floor). The angle that gets published is floor(F/16).
- R5: New outputs are published once per LOCK_HALVES half-cycles, that is after every LOCK_HALVES/2 intervals. `ref_upd` is high for exactly the one clock in which the new `angle_deg` and `ref_pm` first appear. At all other times both outputs hold their values.
- R6: With `curve_sel`=0, `ref_pm` (in 0.1 % units) follows these breakpoints (degrees→code): 18→0, 35→20, 40→30, 45→50, 54→150, 72→350, 90→550, 108→755, 126→955, 130→1000, 144→1000, 180→1000. Between adjacent breakpoints (x0,y0) and (x1,y1), the code is y0 + floor((y1−y0)·(A−x0)/(x1−x0)).
- R7: With `curve_sel`=1, the breakpoints are 18→0, 35→10, 40→20, 45→30, 54→50, 72→100, 90→280, 108→500, 126→750, 130→800, 140→950, 144→1000, with the same interpolation. `curve_sel` is sampled when the outputs are published.
- R8: A published angle below 18 gives `ref_pm`=0. An angle at or above the last breakpoint of the selected curve gives `ref_pm`=1000.
- R9: After reset, `angle_deg`=180, `ref_pm`=1000, and `ref_upd` and `ratio_done` are low.
- R10: `ratio_done` pulses high for exactly one clock per completed interval, once the angle for that interval is known and before the filter takes it in. `ref_upd` follows a `ratio_done` pulse by exactly two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | One-clock pulse at each rectified half-cycle boundary |
| dim_raw | input | 1 | Comparator output, high while the dimmer conducts |
| curve_sel | input | 1 | Dimming curve select: 0 default, 1 alternate |
| angle_deg | output | 8 | Published smoothed conduction angle, degrees |
| ref_pm | output | 10 | Published current reference, 0.1 % units (0..1000) |
| ref_upd | output | 1 | One-clock pulse when new outputs appear |
| ratio_done | output | 1 | One-clock pulse when an interval's angle is ready |

## Verification
A wrong count, quotient or filter state stays hidden until the next publication, up to LOCK_HALVES half-cycles later. After that, `angle_deg` departs from the reference model at the first check that follows the publication, and `ref_pm` departs with it through the curve. Because the filter state carries over, one bad interval keeps skewing the published angle for several publications afterwards. A lost or extra step in the controller shows up as a wrong count of `ratio_done` or `ref_upd` pulses, or as an output that changes with `ref_upd` low. Low angles, top-clamped angles, unequal halves, swallowed glitches and both curves are each driven long enough for the filter to settle near the point under test.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DIVIDE,
        ST_SMOOTH,
        ST_PUBLISH
    } cap_state_e;

    localparam int NPTS     = 12;
    localparam int FULL_DEG = 180;
    localparam int FULL_PM  = 1000;

    // Breakpoint abscissa in degrees; both curves share the first ten points.
    function automatic int bp_deg(input int sel, input int idx);
        case (idx)
            0:       return 18;
            1:       return 35;
            2:       return 40;
            3:       return 45;
            4:       return 54;
            5:       return 72;
            6:       return 90;
            7:       return 108;
            8:       return 126;
            9:       return 130;
            10:      return (sel != 0) ? 140 : 144;
            default: return (sel != 0) ? 144 : 180;
        endcase
    endfunction

    // Breakpoint ordinate in tenths of a percent.
    function automatic int bp_pm(input int sel, input int idx);
        case (idx)
            0:       return 0;
            1:       return (sel != 0) ? 10  : 20;
            2:       return (sel != 0) ? 20  : 30;
            3:       return (sel != 0) ? 30  : 50;
            4:       return (sel != 0) ? 50  : 150;
            5:       return (sel != 0) ? 100 : 350;
            6:       return (sel != 0) ? 280 : 550;
            7:       return (sel != 0) ? 500 : 755;
            8:       return (sel != 0) ? 750 : 955;
            9:       return (sel != 0) ? 800 : 1000;
            10:      return (sel != 0) ? 950 : 1000;
            default: return 1000;
        endcase
    endfunction

endpackage

// File: rtl/cap_deglitch.sv
module cap_deglitch #(
    parameter int FILT_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int CNTW = $clog2(FILT_CYC + 1);

    logic [CNTW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean_o <= 1'b0;
            run_q   <= '0;
        end else if (raw_i == clean_o) begin
            run_q <= '0;
        end else if (run_q == CNTW'(FILT_CYC - 1)) begin
            clean_o <= raw_i;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/cap_span_timer.sv
module cap_span_timer #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          lvl_i,
    output logic          done_o,
    output logic [CW-1:0] high_o,
    output logic [CW-1:0] per_o,
    output logic          edge_o
);
    logic          armed_q;
    logic          second_q;
    logic          lvl_q;
    logic          edge_acc;
    logic [CW-1:0] hi_acc;
    logic [CW-1:0] per_acc;
    logic          toggled;

    assign toggled = (lvl_i != lvl_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            second_q <= 1'b0;
            lvl_q    <= 1'b0;
            edge_acc <= 1'b0;
            hi_acc   <= '0;
            per_acc  <= '0;
            done_o   <= 1'b0;
            high_o   <= '0;
            per_o    <= '0;
            edge_o   <= 1'b0;
        end else begin
            lvl_q  <= lvl_i;
            done_o <= 1'b0;
            if (tick_i && !armed_q) begin
                armed_q  <= 1'b1;
                second_q <= 1'b0;
                hi_acc   <= '0;
                per_acc  <= '0;
                edge_acc <= 1'b0;
            end else if (tick_i && second_q) begin
                done_o   <= 1'b1;
                high_o   <= hi_acc + CW'(lvl_i);
                per_o    <= per_acc + 1'b1;
                edge_o   <= edge_acc | toggled;
                hi_acc   <= '0;
                per_acc  <= '0;
                edge_acc <= 1'b0;
                second_q <= 1'b0;
            end else if (armed_q) begin
                per_acc  <= per_acc + 1'b1;
                hi_acc   <= hi_acc + CW'(lvl_i);
                edge_acc <= edge_acc | toggled;
                if (tick_i) begin
                    second_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cap_divider.sv
module cap_divider #(
    parameter int NW = 28,
    parameter int DW = 20,
    parameter int QW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [NW-1:0] num_i,
    input  logic [DW-1:0] den_i,
    output logic [QW-1:0] quo_o,
    output logic          done_o
);
    localparam int IW = (QW > 1) ? $clog2(QW) : 1;

    logic [NW-1:0] rem_q;
    logic [NW-1:0] den_q;
    logic [IW-1:0] idx_q;
    logic          busy_q;
    logic [NW-1:0] trial;

    assign trial = den_q << idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
            quo_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                rem_q  <= num_i;
                den_q  <= NW'(den_i);
                idx_q  <= IW'(QW - 1);
                busy_q <= 1'b1;
                quo_o  <= '0;
            end else if (busy_q) begin
                if (rem_q >= trial) begin
                    rem_q        <= rem_q - trial;
                    quo_o[idx_q] <= 1'b1;
                end
                if (idx_q == '0) begin
                    busy_q <= 1'b0;
                    done_o <= 1'b1;
                end else begin
                    idx_q <= idx_q - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cap_curve_map.sv
module cap_curve_map (
    input  logic [7:0] ang_i,
    input  logic       sel_i,
    output logic [9:0] pm_o
);
    import cap_pkg::*;

    logic [9:0] pm_by_sel [2];

    for (genvar s = 0; s < 2; s++) begin : g_curve
        always_comb begin
            int a;
            int res;
            a   = int'(ang_i);
            res = 0;
            if (a >= bp_deg(s, NPTS - 1)) begin
                res = bp_pm(s, NPTS - 1);
            end
            for (int i = 0; i < NPTS - 1; i++) begin
                if (a >= bp_deg(s, i) && a < bp_deg(s, i + 1)) begin
                    res = bp_pm(s, i)
                        + ((bp_pm(s, i + 1) - bp_pm(s, i)) * (a - bp_deg(s, i)))
                          / (bp_deg(s, i + 1) - bp_deg(s, i));
                end
            end
            pm_by_sel[s] = 10'(res);
        end
    end

    assign pm_o = pm_by_sel[sel_i];
endmodule

// File: rtl/cangle_ref_proc.sv
module cangle_ref_proc #(
    parameter int FILT_CYC    = 20,
    parameter int CW          = 20,
    parameter int LOCK_HALVES = 32,
    parameter int FRAC        = 4,
    parameter int IIR_SH      = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic       dim_raw,
    input  logic       curve_sel,
    output logic [7:0] angle_deg,
    output logic [9:0] ref_pm,
    output logic       ref_upd,
    output logic       ratio_done
);
    import cap_pkg::*;

    localparam int LOCK_IVL = (LOCK_HALVES >= 2) ? LOCK_HALVES / 2 : 1;
    localparam int LKW      = (LOCK_IVL > 1) ? $clog2(LOCK_IVL) : 1;
    localparam int NW       = CW + 8;
    localparam int FW       = 8 + FRAC + 2;

    cap_state_e state_q, state_d;

    logic          dim_clean;
    logic          meas_vld;
    logic [CW-1:0] meas_hi;
    logic [CW-1:0] meas_per;
    logic          meas_edge;
    logic [NW-1:0] div_num;
    logic [7:0]    div_quo;
    logic          div_fin;
    logic          div_go;
    logic [7:0]    meas_ang_q;
    logic [LKW-1:0] lock_q;
    logic signed [FW-1:0] filt_q;
    logic signed [FW-1:0] tgt_s;
    logic signed [FW-1:0] diff_s;
    logic signed [FW-1:0] filt_d;
    logic [7:0]    pub_ang;
    logic [9:0]    map_pm;
    logic          lock_last;

    cap_deglitch #(.FILT_CYC(FILT_CYC)) u_dgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (dim_raw),
        .clean_o (dim_clean)
    );

    cap_span_timer #(.CW(CW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (half_tick),
        .lvl_i  (dim_clean),
        .done_o (meas_vld),
        .high_o (meas_hi),
        .per_o  (meas_per),
        .edge_o (meas_edge)
    );

    assign div_num = NW'(meas_hi) * NW'(FULL_DEG);

    cap_divider #(.NW(NW), .DW(CW), .QW(8)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_go),
        .num_i   (div_num),
        .den_i   (meas_per),
        .quo_o   (div_quo),
        .done_o  (div_fin)
    );

    assign pub_ang = filt_q[FRAC+7:FRAC];

    cap_curve_map u_map (
        .ang_i (pub_ang),
        .sel_i (curve_sel),
        .pm_o  (map_pm)
    );

    assign tgt_s     = $signed({{(FW-8-FRAC){1'b0}}, meas_ang_q, {FRAC{1'b0}}});
    assign diff_s    = tgt_s - filt_q;
    assign filt_d    = filt_q + (diff_s >>> IIR_SH);
    assign lock_last = (lock_q == LKW'(LOCK_IVL - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (meas_vld) begin
                    state_d = meas_edge ? ST_DIVIDE : ST_SMOOTH;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    state_d = ST_SMOOTH;
                end
            end
            ST_SMOOTH:  state_d = lock_last ? ST_PUBLISH : ST_IDLE;
            ST_PUBLISH: state_d = ST_IDLE;
        endcase
    end

    // controller outputs
    always_comb begin
        div_go     = (state_q == ST_IDLE) && meas_vld && meas_edge;
        ratio_done = (state_q == ST_SMOOTH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_ang_q <= 8'(FULL_DEG);
            filt_q     <= FW'(FULL_DEG << FRAC);
            lock_q     <= '0;
            angle_deg  <= 8'(FULL_DEG);
            ref_pm     <= 10'(FULL_PM);
            ref_upd    <= 1'b0;
        end else begin
            ref_upd <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (meas_vld && !meas_edge) begin
                        meas_ang_q <= 8'(FULL_DEG);
                    end
                end
                ST_DIVIDE: begin
                    if (div_fin) begin
                        meas_ang_q <= div_quo;
                    end
                end
                ST_SMOOTH: begin
                    filt_q <= filt_d;
                    lock_q <= lock_last ? '0 : lock_q + 1'b1;
                end
                ST_PUBLISH: begin
                    angle_deg <= pub_ang;
                    ref_pm    <= map_pm;
                    ref_upd   <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/cap_proc_chk.sv
module cap_proc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] angle_deg,
    input logic [9:0] ref_pm,
    input logic       ref_upd,
    input logic       ratio_done
);
    AST_ANGLE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        angle_deg <= 8'd180); // R2

    AST_REF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pm <= 10'd1000); // R6

    AST_HELD_BETWEEN_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> ($stable(ref_pm) && $stable(angle_deg))); // R5

    AST_UPD_FOLLOWS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |-> $past(ratio_done, 2)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_done |=> !ratio_done); // R10

    AST_TOP_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd && angle_deg >= 8'd144) |-> (ref_pm == 10'd1000)); // R8

    AST_LOW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_upd && angle_deg < 8'd18) |-> (ref_pm == 10'd0)); // R8
endmodule

bind cangle_ref_proc cap_proc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .angle_deg  (angle_deg),
    .ref_pm     (ref_pm),
    .ref_upd    (ref_upd),
    .ratio_done (ratio_done)
);

// File: tb/cangle_ref_proc_tb.sv
module cangle_ref_proc_tb_top;
    localparam int CLK_PER  = 10;
    localparam int HALF_LEN = 200;
    localparam int FILT     = 20;
    localparam int LOCKH    = 8;
    localparam int LOCKI    = LOCKH / 2;
    localparam int WIN_END  = HALF_LEN - 25;

    localparam int XD [12] = '{18, 35, 40, 45, 54, 72, 90, 108, 126, 130, 144, 180};
    localparam int YD [12] = '{0, 20, 30, 50, 150, 350, 550, 755, 955, 1000, 1000, 1000};
    localparam int XA [12] = '{18, 35, 40, 45, 54, 72, 90, 108, 126, 130, 140, 144};
    localparam int YA [12] = '{0, 10, 20, 30, 50, 100, 280, 500, 750, 800, 950, 1000};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       half_tick = 1'b0;
    logic       dim_raw = 1'b0;
    logic       curve_sel = 1'b0;
    logic [7:0] angle_deg;
    logic [9:0] ref_pm;
    logic       ref_upd;
    logic       ratio_done;

    int n_chk = 0;
    int n_bad = 0;
    int upd_cnt = 0;
    int done_cnt = 0;
    int n_ivl = 0;
    bit finished = 1'b0;

    int m_filt = 180 * 16;
    int m_cnt = 0;
    int m_ang = 180;
    int m_ref = 1000;

    int p_c1, p_c2, p_sel;
    string p_tag;
    bit have_prev = 1'b0;

    always #(CLK_PER / 2) clk = ~clk;

    cangle_ref_proc #(
        .FILT_CYC    (FILT),
        .LOCK_HALVES (LOCKH)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .half_tick  (half_tick),
        .dim_raw    (dim_raw),
        .curve_sel  (curve_sel),
        .angle_deg  (angle_deg),
        .ref_pm     (ref_pm),
        .ref_upd    (ref_upd),
        .ratio_done (ratio_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (ref_upd) upd_cnt++;
            if (ratio_done) done_cnt++;
        end
    end

    function automatic int curve_ref(input int a, input int s);
        int xs [12];
        int ys [12];
        for (int i = 0; i < 12; i++) begin
            xs[i] = (s != 0) ? XA[i] : XD[i];
            ys[i] = (s != 0) ? YA[i] : YD[i];
        end
        if (a >= xs[11]) return ys[11];
        for (int i = 0; i < 11; i++) begin
            if (a >= xs[i] && a < xs[i + 1])
                return ys[i] + ((ys[i + 1] - ys[i]) * (a - xs[i])) / (xs[i + 1] - xs[i]);
        end
        return 0;
    endfunction

    // R1, R2, R3, R4, R5 reference model for one finished interval
    task automatic model_update(input int c1, input int c2, input int s);
        int e1, e2, a;
        e1 = (c1 >= FILT) ? c1 : 0;
        e2 = (c2 >= FILT) ? c2 : 0;
        if (e1 > 0 || e2 > 0) a = (180 * (e1 + e2)) / (2 * HALF_LEN);
        else                  a = 180;
        m_filt = m_filt + (((a * 16) - m_filt) >>> 1);
        m_cnt++;
        if (m_cnt == LOCKI) begin
            m_cnt = 0;
            m_ang = m_filt / 16;
            m_ref = curve_ref(m_ang, s);
        end
    endtask

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_half(input int c, input bit chk, input bit set_sel, input int sel_v,
                            input string tag);
        for (int t = 0; t < HALF_LEN; t++) begin
            @(negedge clk);
            if (chk && (t == HALF_LEN / 2 || t == HALF_LEN - 1)) begin
                check_eq(tag, "angle_deg", int'(angle_deg), m_ang);
                check_eq(tag, "ref_pm", int'(ref_pm), m_ref);
            end
            if (set_sel && t == HALF_LEN / 2) curve_sel = sel_v[0];
            half_tick = (t == 0);
            dim_raw   = (c > 0) && (t >= WIN_END - c) && (t < WIN_END);
        end
    endtask

    task automatic run_ivl(input int c1, input int c2, input int s, input string tag);
        if (have_prev) model_update(p_c1, p_c2, p_sel);
        run_half(c1, have_prev, 1'b1, s, p_tag);
        run_half(c2, have_prev, 1'b0, 0, p_tag);
        p_c1 = c1;
        p_c2 = c2;
        p_sel = s;
        p_tag = tag;
        have_prev = 1'b1;
        n_ivl++;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        int seedv;
        seedv = int'($urandom(32'd20240607));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R9 reset values
        check_eq("R9", "angle_deg", int'(angle_deg), 180);
        check_eq("R9", "ref_pm", int'(ref_pm), 1000);
        check_eq("R9", "ref_upd", int'(ref_upd), 0);
        check_eq("R9", "ratio_done", int'(ratio_done), 0);

        repeat (6) run_ivl(100, 100, 0, "R2 R4 R6 symmetric");
        repeat (4) run_ivl(150, 50, 0, "R2 R5 asymmetric");
        repeat (8) run_ivl(0, 0, 0, "R3 no edges");
        repeat (8) run_ivl(60, 60, 0, "R2 R6 low angle");
        repeat (8) run_ivl(8, 8, 0, "R1 glitch swallowed");
        repeat (10) run_ivl(25, 0, 0, "R8 low clamp");
        repeat (8) run_ivl(165, 165, 1, "R8 R7 top clamp");
        repeat (8) run_ivl(100, 100, 1, "R7 alternate curve");
        repeat (4) run_ivl(120, 8, 0, "R1 R2 one half glitched");
        for (int k = 0; k < 24; k++) begin
            int c1, c2, r;
            r  = $urandom_range(0, 9);
            c1 = (r == 0) ? 0 : (r == 1) ? 8 : $urandom_range(25, 165);
            r  = $urandom_range(0, 9);
            c2 = (r == 0) ? 0 : (r == 1) ? 8 : $urandom_range(25, 165);
            run_ivl(c1, c2, $urandom_range(0, 1), "R2 R6 R7 random");
        end
        model_update(p_c1, p_c2, p_sel);
        run_half(0, 1'b1, 1'b0, 0, p_tag);

        check_eq("R10 ratio_done pulses", "count", done_cnt, n_ivl);
        check_eq("R5 ref_upd pulses", "count", upd_cnt, n_ivl / LOCKI);
        finished = 1'b1;
        finish_run();
    end
endmodule